// File: doc/BRIEF.md
# Lockable Keyed Watchdog Timer

This block is a watchdog for a processor subsystem. An 8-bit counter advances on one of four slow tick-enable inputs, chosen by a clock-select field. Two separate 8-bit thresholds compare against the counter. The first raises an interrupt status flag. The second produces a one-clock reset-request pulse. Software keeps the system alive by writing a restart key, which returns the counter to zero. Any other value written to that register does nothing.

A second key locks the watchdog. Once locked, the configuration register can no longer be written and the run bit stays set until the block's own hardware reset. Software reaches everything through a simple synchronous register bus. Read data is registered and appears in the cycle after the address is presented.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset every register reads zero, the counter is zero, the block is unlocked, and `irq_o` and `rst_req_o` are low.
- R2: The configuration register at offset 0x000 is read/write with this layout: bit 0 run, bit 1 interrupt compare enable, bit 2 reset compare enable, bits 15:8 reset threshold, bits 23:16 interrupt threshold, bits 26:24 clock select. All other bits read 0. Read data appears on `bus_rdata` one cycle after the address.
- R3: Clock-select codes 1, 2, 3 and 4 take their tick from `tick_en[0]`, `tick_en[1]`, `tick_en[2]` and `tick_en[3]`. Code 0 and codes 5 to 7 stop the counter, and so does a cleared run bit.
- R4: Each selected tick raises the counter by one. The counter holds at 0xFF.
- R5: Writing 0xB2 in the low byte at offset 0x004 clears the counter, and a restart wins over a tick in the same cycle. Any other value leaves the counter unchanged.
- R6: Writing 0x3A in the low byte at offset 0x008 locks the block and sets the run bit. After that, configuration writes are ignored until hardware reset. Other values do not lock.
- R7: Offset 0x00C returns the counter in bits 7:0, and writes to it are ignored.
- R8: If interrupt compare is enabled, the interrupt status flag (offset 0x204, bit 0) becomes 1 one cycle after the tick that moves the counter onto the interrupt threshold.
- R9: `irq_o` is high exactly when both the status flag and the interrupt enable bit (offset 0x200, bit 0) are 1, and it follows them in the same cycle.
- R10: Writing 1 to bit 0 at offset 0x208 clears the status flag, and writing 1 to bit 0 at offset 0x20C sets it. If a compare hit and a clear happen in the same cycle, the flag ends up set.
- R11: If reset compare is enabled, `rst_req_o` is high for exactly one clock, in the cycle after the tick that moves the counter onto the reset threshold.
- R12: Reads of unmapped offsets, and of the write-only offsets 0x004, 0x008, 0x208 and 0x20C, return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| tick_en | input | NUM_RATES | One-cycle tick strobes, one per supported rate |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The cases hardest to reach from the ports are those that need long or exactly timed sequences. Reaching saturation takes more than 255 selected ticks with no restart. Testing the set-over-clear rule needs a compare hit to land in the same cycle as a clear write. The lock can only be undone by hardware reset, so exercising it rules out any later configuration changes. The stimulus therefore runs a directed run of 260 ticks for saturation. It times a clear write against a tick that lands on the interrupt threshold. It runs the lock sequence only after the constrained-random phase. That random phase uses small thresholds and biases restart keys so that compare hits and restarts happen often.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned SEL_W = 3;

  localparam int unsigned OFS_CFG     = 'h000;
  localparam int unsigned OFS_RESTART = 'h004;
  localparam int unsigned OFS_LOCK    = 'h008;
  localparam int unsigned OFS_COUNT   = 'h00C;
  localparam int unsigned OFS_IE      = 'h200;
  localparam int unsigned OFS_STAT    = 'h204;
  localparam int unsigned OFS_CLR     = 'h208;
  localparam int unsigned OFS_SET     = 'h20C;

  localparam logic [7:0] KEY_RESTART = 8'hB2;
  localparam logic [7:0] KEY_LOCK    = 8'h3A;

  // bit order matches the configuration word layout (bit 0 = run)
  typedef struct packed {
    logic [SEL_W-1:0] clk_sel;
    logic [CNT_W-1:0] irq_cmp;
    logic [CNT_W-1:0] rst_cmp;
    logic [4:0]       rsvd;
    logic             rst_en;
    logic             irq_en;
    logic             run;
  } wdt_cfg_t;

  localparam int unsigned CFG_W = $bits(wdt_cfg_t);
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             lock_we,
  input  logic [CFG_W-1:0] wdata,
  output wdt_cfg_t         cfg_o,
  output logic             locked_o
);
  wdt_cfg_t cfg_q;
  logic     locked_q;
  wdt_cfg_t cfg_new;

  always_comb begin
    cfg_new      = wdt_cfg_t'(wdata);
    cfg_new.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (lock_we && !locked_q) begin
      locked_q  <= 1'b1;
      cfg_q.run <= 1'b1;
    end else if (cfg_we && !locked_q) begin
      cfg_q <= cfg_new;
    end
  end

  assign cfg_o    = cfg_q;
  assign locked_o = locked_q;

  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
  assert_lock_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(cfg_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wdt_cfg_t             cfg_i,
  input  logic [NUM_RATES-1:0] tick_en,
  input  logic                 restart_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 irq_hit_o,
  output logic                 rst_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_RATES-1:0] rate_sel;
  logic                 tick;
  logic                 adv;
  logic [CNT_W-1:0]     count_q, count_nxt;
  logic                 req_q;
  wire                  unused_rsvd = ^cfg_i.rsvd;

  genvar g;
  generate
    for (g = 0; g < NUM_RATES; g++) begin : g_rate
      assign rate_sel[g] = (cfg_i.clk_sel == SEL_W'(g + 1));
    end
  endgenerate

  assign tick = cfg_i.run && |(rate_sel & tick_en);
  assign adv  = tick && !restart_i && (count_q != CNT_MAX);

  always_comb begin
    count_nxt = count_q;
    if (restart_i)  count_nxt = '0;
    else if (adv)   count_nxt = count_q + 1'b1;
  end

  assign irq_hit_o = adv && cfg_i.irq_en && (count_nxt == cfg_i.irq_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      req_q   <= 1'b0;
    end else begin
      count_q <= count_nxt;
      req_q   <= adv && cfg_i.rst_en && (count_nxt == cfg_i.rst_cmp);
    end
  end

  assign count_o   = count_q;
  assign rst_req_o = req_q;

  assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (count_q == '0));
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (count_q != $past(count_q)) |-> (count_q == '0 || count_q == CNT_W'($past(count_q) + 1'b1)));
  assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (count_q == CNT_MAX && !restart_i) |=> (count_q == CNT_MAX));
  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/wdt_irq_ctl.sv
module wdt_irq_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic ie_we,
  input  logic ie_wdata,
  input  logic clr_i,
  input  logic set_i,
  output logic ie_o,
  output logic stat_o,
  output logic irq_o
);
  logic ie_q, stat_q, irq_q;
  logic ie_d, stat_d;

  assign ie_d   = ie_we ? ie_wdata : ie_q;
  assign stat_d = (stat_q && !clr_i) || hit_i || set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ie_q   <= ie_d;
      stat_q <= stat_d;
      irq_q  <= stat_d && ie_d;
    end
  end

  assign ie_o   = ie_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  assert_hit_sets_R8: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> stat_q);
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i && !hit_i) |=> !stat_q);
  assert_set_R10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> stat_q);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_RATES-1:0] tick_en,
  output logic                 irq_o,
  output logic                 rst_req_o
);
  wdt_cfg_t         cfg;
  logic             locked;
  logic [CNT_W-1:0] count;
  logic             irq_hit;
  logic             ie, stat;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic sel_cfg, sel_restart, sel_lock, sel_ie, sel_clr, sel_set;
  assign sel_cfg     = bus_addr == ADDR_W'(OFS_CFG);
  assign sel_restart = bus_addr == ADDR_W'(OFS_RESTART);
  assign sel_lock    = bus_addr == ADDR_W'(OFS_LOCK);
  assign sel_ie      = bus_addr == ADDR_W'(OFS_IE);
  assign sel_clr     = bus_addr == ADDR_W'(OFS_CLR);
  assign sel_set     = bus_addr == ADDR_W'(OFS_SET);

  logic restart, lock_key;
  assign restart  = bus_we && sel_restart && (bus_wdata[7:0] == KEY_RESTART);
  assign lock_key = bus_we && sel_lock && (bus_wdata[7:0] == KEY_LOCK);

  wire unused_wdata = ^bus_wdata[DATA_W-1:CFG_W];

  wdt_cfg_regs u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (bus_we && sel_cfg),
    .lock_we  (lock_key),
    .wdata    (bus_wdata[CFG_W-1:0]),
    .cfg_o    (cfg),
    .locked_o (locked)
  );

  wdt_counter #(.NUM_RATES(NUM_RATES)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .cfg_i     (cfg),
    .tick_en   (tick_en),
    .restart_i (restart),
    .count_o   (count),
    .irq_hit_o (irq_hit),
    .rst_req_o (rst_req_o)
  );

  wdt_irq_ctl u_irq (
    .clk      (clk),
    .rst      (rst),
    .hit_i    (irq_hit),
    .ie_we    (bus_we && sel_ie),
    .ie_wdata (bus_wdata[0]),
    .clr_i    (bus_we && sel_clr && bus_wdata[0]),
    .set_i    (bus_we && sel_set && bus_wdata[0]),
    .ie_o     (ie),
    .stat_o   (stat),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (sel_cfg)                                 rdata_d = DATA_W'(cfg);
    else if (bus_addr == ADDR_W'(OFS_COUNT))     rdata_d = DATA_W'(count);
    else if (sel_ie)                             rdata_d = DATA_W'(ie);
    else if (bus_addr == ADDR_W'(OFS_STAT))      rdata_d = DATA_W'(stat);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  assert_locked_runs_R6: assert property (@(posedge clk) disable iff (rst)
    locked |-> cfg.run);
  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !$past(rst)) |-> (stat && ie));
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_en = '0;
  logic        irq_o, rst_req_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  // reference state
  logic [26:0] m_cfg;
  logic        m_locked, m_stat, m_ie;
  logic [7:0]  m_cnt;

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h000: return {5'b0, m_cfg[26:8], 5'b0, m_cfg[2:0]};
      12'h00C: return {24'b0, m_cnt};
      12'h200: return {31'b0, m_ie};
      12'h204: return {31'b0, m_stat};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cfg = '0; m_locked = 0; m_stat = 0; m_ie = 0; m_cnt = '0;
  endtask

  task automatic apply(input logic we, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] tk, input string tag);
    logic [31:0] e_rd;
    logic restart, st, adv, ih, rh, stat_n, ie_n;
    logic [7:0] nc;
    int cs;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
    e_rd = model_read(a);
    restart = we && a == 12'h004 && d[7:0] == 8'hB2;
    cs = int'(m_cfg[26:24]);
    st = m_cfg[0] && cs >= 1 && cs <= 4 && tk[cs-1];
    adv = st && !restart && m_cnt != 8'hFF;
    nc = restart ? 8'h00 : (adv ? m_cnt + 8'd1 : m_cnt);
    ih = adv && m_cfg[1] && nc == m_cfg[23:16];
    rh = adv && m_cfg[2] && nc == m_cfg[15:8];
    stat_n = (m_stat && !(we && a == 12'h208 && d[0])) || ih || (we && a == 12'h20C && d[0]);
    ie_n = (we && a == 12'h200) ? d[0] : m_ie;
    @(posedge clk);
    #1;
    chk(tag, "rdata", bus_rdata, e_rd);
    chk(tag, "rst_req", {31'b0, rst_req_o}, {31'b0, rh});
    chk(tag, "irq", {31'b0, irq_o}, {31'b0, stat_n && ie_n});
    m_cnt = nc; m_stat = stat_n; m_ie = ie_n;
    if (we && a == 12'h008 && d[7:0] == 8'h3A && !m_locked) begin
      m_locked = 1; m_cfg[0] = 1;
    end else if (we && a == 12'h000 && !m_locked) begin
      m_cfg = {d[26:8], 5'b0, d[2:0]};
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    apply(0, a, 32'h0, 4'h0, tag);
    apply(0, 12'h0FC, 32'h0, 4'h0, tag); // result of a appears now
  endtask

  function automatic logic [31:0] mk_cfg(input int cs, input int iv, input int rv,
                                         input bit ren, input bit ien, input bit run);
    return (32'(cs) << 24) | (32'(iv) << 16) | (32'(rv) << 8) | {29'b0, ren, ien, run};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
    chk("R1", "rst_req after reset", {31'b0, rst_req_o}, 32'h0);
    rd(12'h000, "R1"); rd(12'h00C, "R1"); rd(12'h200, "R1"); rd(12'h204, "R1");

    // R2 layout readback, reserved bits dropped
    apply(1, 12'h000, 32'hFFFF_FFF8 | mk_cfg(1, 3, 5, 1, 1, 1), 4'h0, "R2");
    rd(12'h000, "R2");
    // R4 counting at rate 0, R8 interrupt at 3, R11 reset request at 5
    for (int i = 0; i < 6; i++) apply(0, 12'h00C, 0, 4'b0001, "R4");
    rd(12'h204, "R8");
    // R3 wrong rate tick does nothing
    apply(0, 12'h00C, 0, 4'b1110, "R3");
    rd(12'h00C, "R3");
    apply(1, 12'h000, mk_cfg(5, 3, 5, 1, 1, 1), 4'h0, "R3");
    for (int i = 0; i < 3; i++) apply(0, 12'h00C, 0, 4'hF, "R3");
    apply(1, 12'h000, mk_cfg(4, 9, 8, 1, 1, 1), 4'h0, "R3");
    for (int i = 0; i < 3; i++) apply(0, 12'h00C, 0, 4'b1000, "R3");
    rd(12'h00C, "R3");
    // R5 wrong key then correct key (with a simultaneous tick)
    apply(1, 12'h004, 32'h0000_00B3, 4'b1000, "R5");
    rd(12'h00C, "R5");
    apply(1, 12'h004, 32'hFFFF_FFB2, 4'b1000, "R5");
    rd(12'h00C, "R5");
    // R7 count is read-only
    apply(1, 12'h00C, 32'h55, 4'h0, "R7");
    rd(12'h00C, "R7");
    // R9/R10 enable, clear, set
    apply(1, 12'h200, 32'h1, 4'h0, "R9");
    apply(1, 12'h208, 32'h1, 4'h0, "R10");
    apply(1, 12'h20C, 32'h1, 4'h0, "R10");
    apply(1, 12'h208, 32'h1, 4'h0, "R10");
    // R10 hit coinciding with clear: threshold 1 via restart then tick+clear
    apply(1, 12'h000, mk_cfg(2, 1, 200, 0, 1, 1), 4'h0, "R10");
    apply(1, 12'h004, 32'hB2, 4'h0, "R10");
    apply(1, 12'h208, 32'h1, 4'b0010, "R10");
    rd(12'h204, "R10");
    // R8 interrupt compare disabled: no status
    apply(1, 12'h208, 32'h1, 4'h0, "R8");
    apply(1, 12'h000, mk_cfg(2, 1, 1, 0, 0, 1), 4'h0, "R8");
    apply(1, 12'h004, 32'hB2, 4'h0, "R8");
    apply(0, 12'h204, 0, 4'b0010, "R8");
    rd(12'h204, "R8");
    // R4 saturation
    apply(1, 12'h000, mk_cfg(3, 0, 0, 1, 1, 1), 4'h0, "R4");
    for (int i = 0; i < 260; i++) apply(0, 12'h00C, 0, 4'b0100, "R4");
    rd(12'h00C, "R4");
    // R12 unmapped and write-only offsets
    apply(1, 12'h100, 32'hFFFF_FFFF, 4'h0, "R12");
    apply(1, 12'hFFC, 32'h0000_00B2, 4'h0, "R12");
    rd(12'h004, "R12"); rd(12'h008, "R12"); rd(12'h208, "R12");
    rd(12'h20C, "R12"); rd(12'h100, "R12"); rd(12'h010, "R12");
    rd(12'h000, "R12"); rd(12'h00C, "R12");

    // constrained random phase, no lock
    for (int i = 0; i < 2000; i++) begin
      logic [11:0] addrs [10];
      logic [11:0] a;
      logic [31:0] d;
      addrs = '{12'h000, 12'h004, 12'h00C, 12'h200, 12'h204,
                12'h208, 12'h20C, 12'h010, 12'hFFC, 12'h004};
      a = addrs[$urandom_range(9)];
      d = $urandom;
      if (a == 12'h000) d = mk_cfg($urandom_range(7), $urandom_range(15),
                                   $urandom_range(15), d[2], d[1], 1'b1);
      if (a == 12'h004 && $urandom_range(3) != 0) d[7:0] = 8'hB2;
      apply($urandom_range(3) == 0, a, d, 4'($urandom), "R4");
    end

    // R6 lock
    apply(1, 12'h008, 32'h3B, 4'h0, "R6");
    apply(1, 12'h000, mk_cfg(1, 7, 9, 1, 1, 0), 4'h0, "R6");
    rd(12'h000, "R6");
    apply(1, 12'h008, 32'h3A, 4'h0, "R6");
    rd(12'h000, "R6");
    apply(1, 12'h000, mk_cfg(2, 1, 2, 0, 0, 0), 4'h0, "R6");
    apply(1, 12'h008, 32'h3A, 4'h0, "R6");
    rd(12'h000, "R6");
    apply(1, 12'h004, 32'hB2, 4'h0, "R6");
    for (int i = 0; i < 10; i++) apply(0, 12'h00C, 0, 4'b0001, "R6");
    // hardware reset clears the lock
    @(negedge clk); rst = 1'b1; bus_we = 0; tick_en = 0;
    @(negedge clk); rst = 1'b0; model_reset();
    apply(1, 12'h000, mk_cfg(1, 4, 4, 1, 1, 1), 4'h0, "R1");
    rd(12'h000, "R1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule